// File: doc/BRIEF.md
# Compact Halfword-Instruction Execution Core

This block is a small 32-bit processor core. It executes a narrow set of 16-bit instructions fetched from a byte-addressed, little-endian instruction memory. Each memory read returns one 32-bit word, which holds two instruction halfwords. The core selects the halfword it needs from the program counter.

Three operations are recognised:

- a move of an 8-bit immediate into a low register, which updates the flags;
- a three-register add, which updates the flags;
- a return-through-link encoding, which the core treats as the end of the program.

Any other halfword stops the core and raises an illegal-instruction indication.

Execution runs in three stages: fetch, decode and execute. The program counter steps by 2 for each executed instruction. A surrounding system loads a program, places its first address on the start input, and releases reset. It then waits for the halt output and inspects the register file, the program counter and the flags through a debug read port.

Top module: `hwcore_top`

## Requirements
- R1: While reset (active-low `rstN`) is asserted and right after it, every register reads zero, index 15 of the debug port reads the start address, the flags read 0000, and both `halted` and `illegal` are low.
- R2: The instruction at a halfword address comes from bits [15:0] of the fetched word when address bit 1 is 0, and from bits [31:16] when it is 1. This is little-endian byte order, so the lower byte address holds the low byte of the halfword.
- R3: A halfword with bits [15:11] = 00100 writes the zero-extended bits [7:0] to the register selected by bits [10:8]. It sets N from result bit 31 and Z when the result is zero, and leaves C and V as they were.
- R4: A halfword with bits [15:9] = 0001100 writes the 32-bit sum of the registers selected by bits [5:3] and [8:6] into the register selected by bits [2:0]. The sum wraps modulo 2^32. A register written by one instruction is read correctly by the next one.
- R5: The add sets N from sum bit 31, Z when the sum is zero, C from the carry out of bit 31, and V when both operands have the same sign and the sum has the other sign.
- R6: Each executed move or add advances the program counter by exactly 2. Debug index 15 reads the address of the next instruction to execute.
- R7: Halfword 0x4770 sets `halted`, keeps `illegal` low, and freezes the program counter at the address of that halfword until reset.
- R8: Any halfword that matches none of the three encodings sets both `halted` and `illegal`, and freezes the program counter at its own address.
- R9: Instructions already fetched behind a halting halfword change no register and no flag.
- R10: Debug indices 0 to 14 read the register file. Indices 8 to 14 always read zero, because no instruction can write them.
- R11: The flags output is ordered {N, Z, C, V} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startPc | input | 32 | Address of the first instruction, loaded during reset |
| imemAddr | output | 32 | Word-aligned instruction read address |
| imemRdata | input | 32 | Instruction word, one cycle after the address |
| halted | output | 1 | Execution has stopped |
| illegal | output | 1 | Execution stopped on an unrecognised halfword |
| flagsOut | output | 4 | Condition flags {N, Z, C, V} |
| dbgSel | input | 4 | Debug register index; 15 selects the program counter |
| dbgData | output | 32 | Value of the selected register |

## Verification
The situation hardest to reach is signed overflow and carry out of bit 31. The only operands available are zero-extended 8-bit immediates. To get there, the stimulus loads 0x80 and then chains 24 self-adds that double a register up to 0x80000000, followed by a 25th add that wraps it to zero. A move placed after the wrap checks that C and V persist. The flush case is reached by placing writing instructions directly behind the halting halfword, so they are already in the pipeline when it executes. Some programs start at an address with bit 1 set, so that both halfword positions are decoded.

// File: rtl/hwcore_pkg.sv
package hwcore_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_MOVI = 2'd0,
    OP_ADDR = 2'd1,
    OP_STOP = 2'd2,
    OP_BAD  = 2'd3
  } opKind_e;

  typedef struct packed {
    opKind_e    kind;
    logic [2:0] rd;
    logic [2:0] rn;
    logic [2:0] rm;
    logic [7:0] imm;
  } decInst_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic       selAdd;
    logic [2:0] rd;
    logic [2:0] rn;
    logic [2:0] rm;
    logic [7:0] imm;
  } dpStrobe_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic decInst_t decodeHalf(input logic [15:0] h);
    decInst_t d;
    d.rd   = h[2:0];
    d.rn   = h[5:3];
    d.rm   = h[8:6];
    d.imm  = h[7:0];
    d.kind = OP_BAD;
    if (h[15:11] == 5'b00100) begin
      d.kind = OP_MOVI;
      d.rd   = h[10:8];
    end else if (h[15:9] == 7'b0001100) begin
      d.kind = OP_ADDR;
    end else if (h == 16'h4770) begin
      d.kind = OP_STOP;
    end
    return d;
  endfunction

endpackage

// File: rtl/hwcore_ctrl.sv
module hwcore_ctrl
  import hwcore_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] startPc,
  output logic [ADDR_W-1:0] imemAddr,
  input  logic [DATA_W-1:0] imemRdata,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] archPc,
  output logic              halted,
  output logic              illegal
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] fetchPc;
  logic              decValid;
  logic [ADDR_W-1:0] decPc;
  logic              exValid;
  decInst_t          exInst;
  logic [ADDR_W-1:0] exPc;
  logic              exStop;
  logic              stopNow;
  logic [15:0]       decHalf;
  decInst_t          decNext;

  assign imemAddr = {fetchPc[ADDR_W-1:2], 2'b00};

  // halfword select by address bit 1 (little-endian word)
  assign decHalf = decPc[1] ? imemRdata[31:16] : imemRdata[15:0];
  assign decNext = decodeHalf(decHalf);

  assign exStop  = exValid && ((exInst.kind == OP_STOP) || (exInst.kind == OP_BAD));
  assign stopNow = halted || exStop;

  // fetch stage
  always_ff @(posedge clk) begin
    if (!rstN) fetchPc <= startPc;
    else if (!stopNow) fetchPc <= fetchPc + STEP;
  end

  // decode stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decPc    <= '0;
    end else begin
      decValid <= !stopNow;
      decPc    <= fetchPc;
    end
  end

  // execute stage registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exValid <= 1'b0;
      exInst  <= '0;
      exPc    <= '0;
    end else begin
      exValid <= decValid && !stopNow;
      exInst  <= decNext;
      exPc    <= decPc;
    end
  end

  // retire: program counter and stop state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      archPc  <= startPc;
      halted  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      if (exValid && !exStop) archPc <= exPc + STEP;
      if (exStop) halted <= 1'b1;
      if (exValid && (exInst.kind == OP_BAD)) illegal <= 1'b1;
    end
  end

  always_comb begin
    strobe.wrEn   = exValid && !halted &&
                    ((exInst.kind == OP_MOVI) || (exInst.kind == OP_ADDR));
    strobe.selAdd = (exInst.kind == OP_ADDR);
    strobe.rd     = exInst.rd;
    strobe.rn     = exInst.rn;
    strobe.rm     = exInst.rm;
    strobe.imm    = exInst.imm;
  end

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(archPc));

  assert_illegal_halts_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> halted);

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (archPc == $past(archPc) + STEP));

endmodule

// File: rtl/hwcore_dpath.sv
module hwcore_dpath
  import hwcore_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_COUNT = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic                         halted,
  input  logic [ADDR_W-1:0]            archPc,
  input  logic [$clog2(REG_COUNT)-1:0] dbgSel,
  output logic [DATA_W-1:0]            dbgData,
  output flags_t                       flagsQ
);

  localparam int IDX_W  = $clog2(REG_COUNT);
  localparam int PC_IDX = REG_COUNT - 1;
  localparam int LOW_REGS = 8;

  logic [DATA_W-1:0] regRd [REG_COUNT];
  logic [DATA_W-1:0] opA, opB, result;
  logic [DATA_W:0]   sumWide;
  flags_t            flagsNext;

  // register bank; only the low registers are reachable by writes
  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    if (g < LOW_REGS) begin : gLow
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else if (strobe.wrEn && (IDX_W'(strobe.rd) == IDX_W'(g))) q <= result;
      end
      assign regRd[g] = q;
    end else begin : gHigh
      assign regRd[g] = '0;
    end
  end

  assign opA     = regRd[strobe.rn];
  assign opB     = regRd[strobe.rm];
  assign sumWide = {1'b0, opA} + {1'b0, opB};
  assign result  = strobe.selAdd ? sumWide[DATA_W-1:0] : DATA_W'(strobe.imm);

  always_comb begin
    flagsNext   = flagsQ;
    flagsNext.n = result[DATA_W-1];
    flagsNext.z = (result == '0);
    if (strobe.selAdd) begin
      flagsNext.c = sumWide[DATA_W];
      flagsNext.v = (opA[DATA_W-1] == opB[DATA_W-1]) &&
                    (sumWide[DATA_W-1] != opA[DATA_W-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else if (strobe.wrEn) flagsQ <= flagsNext;
  end

  assign dbgData = (dbgSel == IDX_W'(PC_IDX)) ? DATA_W'(archPc) : regRd[dbgSel];

  assert_no_write_halted_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !strobe.wrEn);

  assert_move_keeps_cv_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.selAdd) |=> (flagsQ.c == $past(flagsQ.c)) &&
                                        (flagsQ.v == $past(flagsQ.v)));

  assert_flags_hold_halted_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(flagsQ));

endmodule

// File: rtl/hwcore_top.sv
module hwcore_top
  import hwcore_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_COUNT = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            startPc,
  output logic [ADDR_W-1:0]            imemAddr,
  input  logic [DATA_W-1:0]            imemRdata,
  output logic                         halted,
  output logic                         illegal,
  output logic [3:0]                   flagsOut,
  input  logic [$clog2(REG_COUNT)-1:0] dbgSel,
  output logic [DATA_W-1:0]            dbgData
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] archPc;
  flags_t            flagsQ;

  hwcore_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startPc  (startPc),
    .imemAddr (imemAddr),
    .imemRdata(imemRdata),
    .strobe   (strobe),
    .archPc   (archPc),
    .halted   (halted),
    .illegal  (illegal)
  );

  hwcore_dpath #(.ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .halted (halted),
    .archPc (archPc),
    .dbgSel (dbgSel),
    .dbgData(dbgData),
    .flagsQ (flagsQ)
  );

  assign flagsOut = {flagsQ.n, flagsQ.z, flagsQ.c, flagsQ.v};

endmodule

// File: tb/hwcore_top_tb.sv
`timescale 1ns/100ps
module hwcore_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] startPc = 32'h0;
  logic [31:0] imemAddr;
  logic [31:0] imemRdata;
  logic        halted, illegal;
  logic [3:0]  flagsOut;
  logic [3:0]  dbgSel = 4'd15;
  logic [31:0] dbgData;

  logic [31:0] mem [0:255];
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) imemRdata <= mem[imemAddr[9:2]];

  hwcore_top dut_i (
    .clk(clk), .rstN(rstN), .startPc(startPc), .imemAddr(imemAddr),
    .imemRdata(imemRdata), .halted(halted), .illegal(illegal),
    .flagsOut(flagsOut), .dbgSel(dbgSel), .dbgData(dbgData)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic putHalf(input logic [31:0] addr, input logic [15:0] val);
    if (addr[1]) mem[addr[9:2]][31:16] = val;
    else         mem[addr[9:2]][15:0]  = val;
  endtask

  task automatic readReg(input int idx, output logic [31:0] val);
    dbgSel = 4'(idx);
    #0.5;
    val = dbgData;
    dbgSel = 4'd15;
  endtask

  task automatic startCore(input logic [31:0] pc);
    @(negedge clk);
    rstN = 1'b0;
    startPc = pc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // runs until halt, checking every PC step is +2 (R6)
  task automatic runToHalt(input logic [31:0] start, input int expSteps);
    logic [31:0] lastPc;
    int steps = 0;
    int guard = 0;
    lastPc = start;
    dbgSel = 4'd15;
    while (!halted && guard < 500) begin
      @(negedge clk);
      guard++;
      if (dbgData !== lastPc) begin
        check("R6", "pc step", dbgData, lastPc + 32'd2);
        lastPc = dbgData;
        steps++;
      end
    end
    check("R7", "halted reached", {31'd0, halted}, 32'd1);
    check("R6", "executed count", steps, expSteps);
  endtask

  task automatic testExample();
    logic [31:0] v;
    putHalf(32'h100, 16'h2100);
    putHalf(32'h102, 16'h2201);
    putHalf(32'h104, 16'h188B);
    putHalf(32'h106, 16'h2000);
    putHalf(32'h108, 16'h4770);
    putHalf(32'h10A, 16'h2509);   // behind halt, must not run (R9)
    putHalf(32'h10C, 16'h2609);
    startCore(32'h100);
    runToHalt(32'h100, 4);
    readReg(3, v); check("R4", "sum reg3", v, 32'd1);
    readReg(2, v); check("R3", "imm reg2", v, 32'd1);
    readReg(1, v); check("R3", "imm reg1", v, 32'd0);
    readReg(0, v); check("R3", "imm reg0", v, 32'd0);
    check("R11", "flags after move zero", {28'd0, flagsOut}, 32'b0100);
    check("R7", "illegal low", {31'd0, illegal}, 32'd0);
    repeat (6) @(negedge clk);
    readReg(15, v); check("R7", "pc frozen", v, 32'h108);
    readReg(5, v); check("R9", "reg5 untouched", v, 32'd0);
    readReg(6, v); check("R9", "reg6 untouched", v, 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    @(negedge clk);
    rstN = 1'b0;
    startPc = 32'h202;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      readReg(i, v); check("R1", $sformatf("reg%0d cleared", i), v, 32'd0);
    end
    readReg(15, v); check("R1", "pc loaded", v, 32'h202);
    check("R1", "flags clear", {28'd0, flagsOut}, 32'd0);
    check("R1", "halt clear", {30'd0, halted, illegal}, 32'd0);
  endtask

  task automatic loadDoubling(input logic [31:0] base, input int adds,
                              output logic [31:0] nextAddr);
    putHalf(base, 16'h2180);
    for (int i = 0; i < adds; i++) putHalf(base + 32'(2 + 2*i), 16'h1849);
    nextAddr = base + 32'(2 + 2*adds);
  endtask

  // odd halfword start exercises upper-half selection (R2)
  task automatic testOverflow();
    logic [31:0] a, v;
    loadDoubling(32'h202, 24, a);
    putHalf(a, 16'h4770);
    startCore(32'h202);
    runToHalt(32'h202, 25);
    readReg(1, v); check("R2", "doubled reg1", v, 32'h8000_0000);
    check("R5", "flags N,V set", {28'd0, flagsOut}, 32'b1001);
    readReg(15, v); check("R7", "halt pc", v, a);
  endtask

  task automatic testCarry();
    logic [31:0] a, v;
    loadDoubling(32'h302, 25, a);
    putHalf(a, 16'h2205);
    putHalf(a + 32'd2, 16'h4770);
    startCore(32'h302);
    runToHalt(32'h302, 27);
    readReg(1, v); check("R4", "wrapped reg1", v, 32'd0);
    readReg(2, v); check("R3", "imm reg2", v, 32'd5);
    check("R3", "C,V kept after move", {28'd0, flagsOut}, 32'b0011);
  endtask

  task automatic testCarryFlags();
    logic [31:0] a, v;
    loadDoubling(32'h380, 25, a);
    putHalf(a, 16'h4770);
    startCore(32'h380);
    runToHalt(32'h380, 26);
    check("R5", "flags Z,C,V on wrap", {28'd0, flagsOut}, 32'b0111);
    readReg(13, v); check("R10", "reg13 zero", v, 32'd0);
    readReg(14, v); check("R10", "reg14 zero", v, 32'd0);
  endtask

  task automatic testIllegal();
    logic [31:0] v;
    putHalf(32'h400, 16'h24AA);
    putHalf(32'h402, 16'hBE00);
    putHalf(32'h404, 16'h2501);
    startCore(32'h400);
    runToHalt(32'h400, 1);
    check("R8", "illegal set", {31'd0, illegal}, 32'd1);
    readReg(4, v); check("R3", "reg4 imm", v, 32'hAA);
    check("R3", "flags N0 Z0", {28'd0, flagsOut}, 32'b0000);
    repeat (4) @(negedge clk);
    readReg(5, v); check("R9", "reg5 after illegal", v, 32'd0);
    readReg(15, v); check("R8", "pc at bad halfword", v, 32'h402);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    testExample();
    testReset();
    testOverflow();
    testCarry();
    testCarryFlags();
    testIllegal();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule